// File: doc/BRIEF.md
# Power Domain On/Off Sequencer

This block switches one hardware power domain on or off. It first checks whether the domain is already in the requested state. If it is not, it runs a fixed sequence: it turns on the domain's clocks, saves or restores the interconnect quality-of-service settings, drives an idle-request handshake with the bus fabric, operates the power switch, and turns the clocks off again. Each phase that waits on a reply has its own timeout. When a timeout expires, the block stops and reports an error.

A command is one cycle of `cmdValid`, with `cmdOn` giving the target state. The sequencer then reports `busy` until it pulses `done` or raises `err`. Three parameters each remove one part of the sequence: a domain may lack a power-switch bit, an idle-request bit, or a power-status bit. A fourth parameter selects between two register write styles. In the masked style, each write carries an enable bit beside the data bit. In the plain style, the enable bit is left zero.

Top module: `pd_sequencer`

## Requirements
- R1: While reset is asserted, and after its release, `idleReq`, `pwrOff`, `clkEn`, `done`, `err`, `busy`, `reqWe` and `pwrWe` are all 0.
- R2: A command whose target already matches the domain state makes no register write, never raises any `clkEn` bit, and pulses `done` in the cycle after the command is accepted.
- R3: Power-off order: all clocks enabled, `qosSave` pulse, request write with data 1, wait for `ackIn`=1, wait for `idleIn`=1, power write with data 1, wait for the domain to read off, clocks disabled, `done`.
- R4: Power-on order: all clocks enabled, power write with data 0, wait for the domain to read on, request write with data 0, wait for `ackIn`=0, wait for `idleIn`=0, `qosRestore` pulse, clocks disabled, `done`.
- R5: The domain is on when `statusIn` is 0 and off when it is 1. A domain built without a status bit counts as on when `idleIn` is 0.
- R6: A domain built without a request bit skips the request write and both of its waits. A domain built without a power bit never pulses `pwrWe` and skips the power wait.
- R7: A wait phase that is not satisfied raises `err` exactly TIMEOUT_CYCLES = CLK_FREQ_MHZ*TIMEOUT_US cycles after the write that opened it. The block then returns to idle (`busy`=0) and leaves `idleReq`, `pwrOff` and `clkEn` unchanged.
- R8: `err` stays at 1 until the next command is accepted. It reads 0 from the cycle after that acceptance.
- R9: `reqWd` and `pwrWd` are {enable, data}. In the masked style, enable is 1 on every write, so a release writes 2'b10. In the plain style, enable is 0.
- R10: Clock enables turn on one per cycle from bit 0 upwards, and turn off one per cycle from the top bit downwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | One-cycle command strobe, taken when not busy |
| cmdOn | input | 1 | Target state: 1 on, 0 off |
| ackIn | input | 1 | Idle acknowledge from the fabric |
| idleIn | input | 1 | Idle status from the fabric |
| statusIn | input | 1 | Power status, 1 = off |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Timeout flag, held until the next command |
| clkEn | output | NUM_CLKS | Domain clock enables |
| qosSave | output | 1 | Pulse: capture the QoS settings |
| qosRestore | output | 1 | Pulse: write back the QoS settings |
| idleReq | output | 1 | Current idle-request level |
| reqWe | output | 1 | Request register write strobe |
| reqWd | output | 2 | Request write {enable, data} |
| pwrOff | output | 1 | Current power-switch level, 1 = off |
| pwrWe | output | 1 | Power register write strobe |
| pwrWd | output | 2 | Power write {enable, data} |

## Verification
The bench drives a fabric and switch model with random reply delays. It checks the relative order of the save, request, power, restore and done events in both directions. If a design swapped the handshake and the power write, it would cut power while traffic is still live, and the event stamps would show the swap. Separate corner cases cover:
- a command to the state the domain is already in, where any stray write or clock toggle would show up;
- a stalled acknowledge and a stalled status bit, where an off-by-one timer would move `err` away from exactly TIMEOUT_CYCLES;
- an idle-only domain with no power or status bit, where a design that did not skip the power phase would pulse `pwrWe` or hang.

// File: rtl/pd_seq_pkg.sv
package pd_seq_pkg;
  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic clkUp;
    logic clkDown;
    logic qosSave;
    logic qosRestore;
    logic reqWr;
    logic reqVal;
    logic pwrWr;
    logic pwrVal;
    logic tmrClr;
    logic setDone;
    logic setErr;
    logic clrErr;
  } seqStrobe_t;

  typedef enum logic [3:0] {
    S_IDLE, S_CLKUP, S_SAVE, S_REQ, S_ACK, S_IDLEWT,
    S_PWR, S_PWRWT, S_RESTORE, S_CLKDN
  } seqState_t;
endpackage

// File: rtl/pd_seq_ctrl.sv
module pd_seq_ctrl
  import pd_seq_pkg::*;
#(
  parameter bit HAS_PWR    = 1'b1,
  parameter bit HAS_REQ    = 1'b1,
  parameter bit HAS_STATUS = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic       cmdOn,
  input  logic       ackIn,
  input  logic       idleIn,
  input  logic       statusIn,
  input  logic       clkAllOn,
  input  logic       clkAllOff,
  input  logic       tmrExpired,
  output seqStrobe_t strb,
  output logic       busy
);
  // Successor states that depend on which bits the domain has.
  localparam seqState_t OFF_AFTER_SAVE = HAS_REQ ? S_REQ : (HAS_PWR ? S_PWR : S_CLKDN);
  localparam seqState_t OFF_AFTER_IDLE = HAS_PWR ? S_PWR : S_CLKDN;
  localparam seqState_t ON_AFTER_CLK   = HAS_PWR ? S_PWR : (HAS_REQ ? S_REQ : S_RESTORE);
  localparam seqState_t ON_AFTER_PWR   = HAS_REQ ? S_REQ : S_RESTORE;

  seqState_t state, nextState;
  logic dirOn;
  logic domOn;

  // Status bit 1 means off; idle-only domains read on as "not idle".
  assign domOn = HAS_STATUS ? ~statusIn : ~idleIn;
  assign busy  = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      dirOn <= 1'b1;
    end else begin
      state <= nextState;
      if (state == S_IDLE && cmdValid) dirOn <= cmdOn;
    end
  end

  always_comb begin
    strb      = '0;
    nextState = state;
    case (state)
      S_IDLE: if (cmdValid) begin
        strb.clrErr = 1'b1;
        if (domOn == cmdOn) strb.setDone = 1'b1;
        else nextState = S_CLKUP;
      end
      S_CLKUP: begin
        if (clkAllOn) nextState = dirOn ? ON_AFTER_CLK : S_SAVE;
        else strb.clkUp = 1'b1;
      end
      S_SAVE: begin
        strb.qosSave = 1'b1;
        nextState    = OFF_AFTER_SAVE;
      end
      S_REQ: begin
        strb.reqWr  = 1'b1;
        strb.reqVal = ~dirOn;
        strb.tmrClr = 1'b1;
        nextState   = S_ACK;
      end
      S_ACK: begin
        if (ackIn == ~dirOn) begin
          strb.tmrClr = 1'b1;
          nextState   = S_IDLEWT;
        end else if (tmrExpired) begin
          strb.setErr = 1'b1;
          nextState   = S_IDLE;
        end
      end
      S_IDLEWT: begin
        if (idleIn == ~dirOn) nextState = dirOn ? S_RESTORE : OFF_AFTER_IDLE;
        else if (tmrExpired) begin
          strb.setErr = 1'b1;
          nextState   = S_IDLE;
        end
      end
      S_PWR: begin
        strb.pwrWr  = 1'b1;
        strb.pwrVal = ~dirOn;
        strb.tmrClr = 1'b1;
        nextState   = S_PWRWT;
      end
      S_PWRWT: begin
        if (domOn == dirOn) nextState = dirOn ? ON_AFTER_PWR : S_CLKDN;
        else if (tmrExpired) begin
          strb.setErr = 1'b1;
          nextState   = S_IDLE;
        end
      end
      S_RESTORE: begin
        strb.qosRestore = 1'b1;
        nextState       = S_CLKDN;
      end
      S_CLKDN: begin
        if (clkAllOff) begin
          strb.setDone = 1'b1;
          nextState    = S_IDLE;
        end else strb.clkDown = 1'b1;
      end
      default: nextState = S_IDLE;
    endcase
  end

  // Every register action happens with all domain clocks running.
  assert_action_clk_R10: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_SAVE || state == S_REQ || state == S_PWR || state == S_RESTORE) |-> clkAllOn);
endmodule

// File: rtl/pd_seq_datapath.sv
module pd_seq_datapath
  import pd_seq_pkg::*;
#(
  parameter int unsigned NUM_CLKS       = 2,
  parameter int unsigned TIMEOUT_CYCLES = 1000,
  parameter bit          MASKED         = 1'b0
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobe_t          strb,
  output logic [NUM_CLKS-1:0] clkEn,
  output logic                clkAllOn,
  output logic                clkAllOff,
  output logic                tmrExpired,
  output logic                idleReq,
  output logic                reqWe,
  output logic [1:0]          reqWd,
  output logic                pwrOff,
  output logic                pwrWe,
  output logic [1:0]          pwrWd,
  output logic                qosSave,
  output logic                qosRestore,
  output logic                done,
  output logic                err
);
  localparam int unsigned TW = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [TW-1:0] TMR_LAST = TW'(TIMEOUT_CYCLES - 1);

  logic [TW-1:0] tmrCnt;
  logic          wrEnBit;

  // The enable half of each write is fixed by the register style.
  generate
    if (MASKED) begin : g_masked
      assign wrEnBit = 1'b1;
    end else begin : g_plain
      assign wrEnBit = 1'b0;
    end
  endgenerate

  assign clkAllOn   = &clkEn;
  assign clkAllOff  = ~|clkEn;
  assign tmrExpired = (tmrCnt == TMR_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkEn      <= '0;
      tmrCnt     <= '0;
      idleReq    <= 1'b0;
      reqWe      <= 1'b0;
      reqWd      <= 2'b00;
      pwrOff     <= 1'b0;
      pwrWe      <= 1'b0;
      pwrWd      <= 2'b00;
      qosSave    <= 1'b0;
      qosRestore <= 1'b0;
      done       <= 1'b0;
      err        <= 1'b0;
    end else begin
      // Enables fill from bit 0 upwards and drain from the top bit down.
      if (strb.clkUp)        clkEn <= (clkEn << 1) | NUM_CLKS'(1);
      else if (strb.clkDown) clkEn <= clkEn >> 1;

      if (strb.tmrClr)       tmrCnt <= '0;
      else if (!tmrExpired)  tmrCnt <= tmrCnt + 1'b1;

      reqWe <= strb.reqWr;
      if (strb.reqWr) begin
        idleReq <= strb.reqVal;
        reqWd   <= {wrEnBit, strb.reqVal};
      end
      pwrWe <= strb.pwrWr;
      if (strb.pwrWr) begin
        pwrOff <= strb.pwrVal;
        pwrWd  <= {wrEnBit, strb.pwrVal};
      end

      qosSave    <= strb.qosSave;
      qosRestore <= strb.qosRestore;
      done       <= strb.setDone;
      if (strb.setErr)      err <= 1'b1;
      else if (strb.clrErr) err <= 1'b0;
    end
  end

  // Enables always form a contiguous run from bit 0.
  assert_clk_contig_R10: assert property (@(posedge clk) disable iff (!rstN)
    ((clkEn + 1'b1) & clkEn) == '0);
  // No more than one enable changes per cycle.
  assert_clk_step_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(clkEn ^ $past(clkEn)));
  // The QoS capture happens with every clock running.
  assert_save_clk_R3: assert property (@(posedge clk) disable iff (!rstN)
    qosSave |-> clkAllOn);
endmodule

// File: rtl/pd_sequencer.sv
module pd_sequencer
  import pd_seq_pkg::*;
#(
  parameter int unsigned CLK_FREQ_MHZ = 100,
  parameter int unsigned TIMEOUT_US   = 10000,
  parameter int unsigned NUM_CLKS     = 2,
  parameter bit          HAS_PWR      = 1'b1,
  parameter bit          HAS_REQ      = 1'b1,
  parameter bit          HAS_STATUS   = 1'b1,
  parameter bit          MASKED       = 1'b0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cmdValid,
  input  logic                cmdOn,
  input  logic                ackIn,
  input  logic                idleIn,
  input  logic                statusIn,
  output logic                busy,
  output logic                done,
  output logic                err,
  output logic [NUM_CLKS-1:0] clkEn,
  output logic                qosSave,
  output logic                qosRestore,
  output logic                idleReq,
  output logic                reqWe,
  output logic [1:0]          reqWd,
  output logic                pwrOff,
  output logic                pwrWe,
  output logic [1:0]          pwrWd
);
  localparam int unsigned TIMEOUT_CYCLES = CLK_FREQ_MHZ * TIMEOUT_US;

  seqStrobe_t strb;
  logic clkAllOn, clkAllOff, tmrExpired;

  pd_seq_ctrl #(
    .HAS_PWR(HAS_PWR), .HAS_REQ(HAS_REQ), .HAS_STATUS(HAS_STATUS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOn(cmdOn),
    .ackIn(ackIn), .idleIn(idleIn), .statusIn(statusIn),
    .clkAllOn(clkAllOn), .clkAllOff(clkAllOff), .tmrExpired(tmrExpired),
    .strb(strb), .busy(busy)
  );

  pd_seq_datapath #(
    .NUM_CLKS(NUM_CLKS), .TIMEOUT_CYCLES(TIMEOUT_CYCLES), .MASKED(MASKED)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .clkEn(clkEn),
    .clkAllOn(clkAllOn), .clkAllOff(clkAllOff), .tmrExpired(tmrExpired),
    .idleReq(idleReq), .reqWe(reqWe), .reqWd(reqWd),
    .pwrOff(pwrOff), .pwrWe(pwrWe), .pwrWd(pwrWd),
    .qosSave(qosSave), .qosRestore(qosRestore), .done(done), .err(err)
  );

  // With a request bit present, power is only cut while idle is requested.
  generate
    if (HAS_REQ) begin : g_req_chk
      assert_off_after_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
        (pwrWe && pwrWd[0]) |-> idleReq);
    end
  endgenerate
endmodule

// File: tb/pd_sequencer_tb.sv
module pd_sequencer_tb;
  localparam int T = 100;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  // Full domain, masked style, three clocks.
  logic cmdValid = 0, cmdOn = 0, ackIn = 0, idleIn = 0, statusIn = 0;
  logic busy, done, err, qosSave, qosRestore, idleReq, reqWe, pwrOff, pwrWe;
  logic [2:0] clkEn;
  logic [1:0] reqWd, pwrWd;
  // Idle-only domain, plain style.
  logic cmdValid2 = 0, cmdOn2 = 0, ackIn2 = 0, idleIn2 = 0;
  logic busy2, done2, err2, qosSave2, qosRestore2, idleReq2, reqWe2, pwrOff2, pwrWe2;
  logic [0:0] clkEn2;
  logic [1:0] reqWd2, pwrWd2;

  pd_sequencer #(.CLK_FREQ_MHZ(100), .TIMEOUT_US(1), .NUM_CLKS(3), .MASKED(1'b1)) u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOn(cmdOn), .ackIn(ackIn),
    .idleIn(idleIn), .statusIn(statusIn), .busy(busy), .done(done), .err(err),
    .clkEn(clkEn), .qosSave(qosSave), .qosRestore(qosRestore), .idleReq(idleReq),
    .reqWe(reqWe), .reqWd(reqWd), .pwrOff(pwrOff), .pwrWe(pwrWe), .pwrWd(pwrWd));

  pd_sequencer #(.CLK_FREQ_MHZ(100), .TIMEOUT_US(1), .NUM_CLKS(1), .HAS_PWR(1'b0),
                 .HAS_STATUS(1'b0), .MASKED(1'b0)) u_dutIdle (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid2), .cmdOn(cmdOn2), .ackIn(ackIn2),
    .idleIn(idleIn2), .statusIn(1'b0), .busy(busy2), .done(done2), .err(err2),
    .clkEn(clkEn2), .qosSave(qosSave2), .qosRestore(qosRestore2), .idleReq(idleReq2),
    .reqWe(reqWe2), .reqWd(reqWd2), .pwrOff(pwrOff2), .pwrWe(pwrWe2), .pwrWd(pwrWd2));

  // Fabric and switch model with random reply delays.
  logic stallAck = 0, stallPwr = 0;
  always @(posedge clk) begin
    if (!rstN) begin
      ackIn <= 0; idleIn <= 0; statusIn <= 0; ackIn2 <= 0; idleIn2 <= 0;
    end else begin
      if (!stallAck && $urandom_range(0, 1) == 1) ackIn <= idleReq;
      if ($urandom_range(0, 1) == 1) idleIn <= ackIn;
      if (!stallPwr && $urandom_range(0, 1) == 1) statusIn <= pwrOff;
      if ($urandom_range(0, 1) == 1) ackIn2 <= idleReq2;
      if ($urandom_range(0, 1) == 1) idleIn2 <= ackIn2;
    end
  end

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Event monitors.
  int tSave, tReq, tPwr, tRest, tErr, nReq, nPwr, nClkChg, clkBad;
  int nReq2, nPwr2, nSave2;
  logic [1:0] lastReqWd, lastPwrWd, lastReqWd2;
  logic [2:0] prevClk = 3'b000;
  always @(negedge clk) begin
    if (qosSave) tSave = cyc;
    if (qosRestore) tRest = cyc;
    if (reqWe) begin tReq = cyc; nReq++; lastReqWd = reqWd; end
    if (pwrWe) begin tPwr = cyc; nPwr++; lastPwrWd = pwrWd; end
    if (err && tErr < 0) tErr = cyc;
    if (clkEn != prevClk) begin
      nClkChg++;
      if (clkEn != ((prevClk << 1) | 3'b001) && clkEn != (prevClk >> 1)) clkBad++;
    end
    prevClk = clkEn;
    if (reqWe2) begin nReq2++; lastReqWd2 = reqWd2; end
    if (pwrWe2) nPwr2++;
    if (qosSave2) nSave2++;
  end

  int checks = 0, failures = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clrStamps();
    tSave = -1; tReq = -1; tPwr = -1; tRest = -1; tErr = -1;
    nReq = 0; nPwr = 0; nClkChg = 0; nReq2 = 0; nPwr2 = 0; nSave2 = 0;
  endtask

  // Issue a command and wait for done or err; lat counts cycles after acceptance.
  task automatic issue(input bit sel, input bit on, output int lat, output bit gotDone);
    @(negedge clk);
    clrStamps();
    if (sel) begin cmdValid2 = 1; cmdOn2 = on; end
    else begin cmdValid = 1; cmdOn = on; end
    @(negedge clk);
    cmdValid = 0; cmdValid2 = 0;
    lat = 0;
    gotDone = sel ? done2 : done;
    while (!(sel ? (done2 || err2) : (done || err)) && lat < 3000) begin
      @(negedge clk);
      lat++;
      gotDone = sel ? done2 : done;
    end
    #1;
  endtask

  function automatic bit orderedOff();
    return tSave >= 0 && tSave < tReq && tReq < tPwr;
  endfunction
  function automatic bit orderedOn();
    return tPwr >= 0 && tPwr < tReq && tReq < tRest;
  endfunction

  initial begin
    int lat;
    bit gd;
    bit expOn;
    void'($urandom(32'h5eed));
    clrStamps();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({idleReq, pwrOff, clkEn, done, err, busy, reqWe, pwrWe} == 0, "R1 reset outputs", int'(clkEn), 0);
    rstN = 1;
    repeat (2) @(negedge clk);
    chk({idleReq, pwrOff, busy, err} == 0, "R1 after release", int'({idleReq, pwrOff, busy, err}), 0);

    // R2 already on
    issue(0, 1, lat, gd);
    chk(gd && lat == 0, "R2 done latency", lat, 0);
    chk(nReq + nPwr + nClkChg == 0, "R2 no action", nReq + nPwr + nClkChg, 0);

    // R3 power off
    issue(0, 0, lat, gd);
    chk(gd && orderedOff(), "R3 off ordering", tReq, tSave + 1);
    chk(pwrOff && idleReq && statusIn, "R3/R5 off final", int'({pwrOff, idleReq, statusIn}), 7);
    chk(clkEn == 0 && clkBad == 0 && nClkChg == 6, "R10 clock sequence", clkBad, 0);
    chk(lastReqWd == 2'b11 && lastPwrWd == 2'b11, "R9 masked assert", int'(lastReqWd), 3);

    // R4 power on
    issue(0, 1, lat, gd);
    chk(gd && orderedOn(), "R4 on ordering", tReq, tPwr + 1);
    chk(!pwrOff && !idleReq && !statusIn, "R4/R5 on final", int'({pwrOff, idleReq, statusIn}), 0);
    chk(lastReqWd == 2'b10 && lastPwrWd == 2'b10, "R9 masked release", int'(lastReqWd), 2);

    // Random command mix (R2, R3, R4)
    expOn = 1;
    for (int i = 0; i < 24; i++) begin
      bit c;
      c = 1'($urandom_range(0, 1));
      issue(0, c, lat, gd);
      if (c == expOn)
        chk(gd && nReq == 0 && nPwr == 0, "R2 random no-op", nReq + nPwr, 0);
      else
        chk(gd && nReq == 1 && nPwr == 1 && (c ? orderedOn() : orderedOff()),
            c ? "R4 random on" : "R3 random off", nReq + nPwr, 2);
      expOn = c;
      chk(pwrOff == !expOn && !err, "R5 random state", int'(pwrOff), int'(!expOn));
    end
    chk(clkBad == 0, "R10 reverse disable", clkBad, 0);

    // Make sure the domain is on before the timeout tests
    issue(0, 1, lat, gd);
    // R7 acknowledge timeout
    stallAck = 1;
    issue(0, 0, lat, gd);
    chk(!gd && err && tErr - tReq == T, "R7 ack timeout", tErr - tReq, T);
    chk(idleReq && !pwrOff && nPwr == 0 && !busy && clkEn == 3'b111, "R7 outputs held",
        int'({idleReq, pwrOff, busy}), 4);
    repeat (20) @(negedge clk);
    chk(err == 1, "R8 err held", int'(err), 1);
    stallAck = 0;
    repeat (10) @(negedge clk);
    issue(0, 1, lat, gd);
    chk(gd && err == 0, "R8 err cleared by command", int'(err), 0);
    issue(0, 0, lat, gd);
    chk(gd && pwrOff && !err, "R3 recovery off", int'(pwrOff), 1);

    // R7 power-status timeout
    stallPwr = 1;
    issue(0, 1, lat, gd);
    chk(!gd && err && tErr - tPwr == T, "R7 power timeout", tErr - tPwr, T);
    stallPwr = 0;
    repeat (5) @(negedge clk);

    // R6/R5 idle-only domain
    issue(1, 0, lat, gd);
    chk(gd && idleReq2 && nPwr2 == 0 && nSave2 == 1, "R6 idle-only off", nPwr2, 0);
    chk(lastReqWd2 == 2'b01, "R9 plain assert", int'(lastReqWd2), 1);
    issue(1, 0, lat, gd);
    chk(gd && lat == 0 && nReq2 == 0, "R5 idle-only already off", nReq2, 0);
    issue(1, 1, lat, gd);
    chk(gd && !idleReq2 && nPwr2 == 0 && lastReqWd2 == 2'b00, "R6 idle-only on",
        int'(lastReqWd2), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule